// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of four DMA channels may use a shared bus, and it keeps the CPU as the default owner of that bus. Each channel has an enable and a request line. A `sample_i` strobe marks the end of a sampling period. On that cycle every enabled channel that is requesting sets a one-bit pending flag, and all such flags are set on the same clock edge. A flag cannot count, so several requests made while it is set produce one transfer only.

When the bus is free and the CPU has finished its access, the pending channel with the lowest index is granted. Its flag is cleared on the edge that raises the grant. The channel keeps the grant until `xfer_done_i` reports that its single transfer has ended. The bus then goes back to the CPU, and no channel can be granted again until `cpu_done_i` reports one completed CPU access. Address generation, transfer counting and the data path belong to other blocks.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset all pending flags are 0, `grant_o` is 0 and `cpu_own_o` is 1.
- R2: On a clock edge where `sample_i` is 1, pending bit i is set for every channel with `ch_en_i[i]`=1 and `ch_req_i[i]`=1. The new value is visible on `pend_o` after that edge. Requests on cycles where `sample_i` is 0 have no effect.
- R3: A channel with `ch_en_i[i]`=0 never sets its pending bit. Lowering `ch_en_i[i]` clears pending bit i on the next edge.
- R4: When several channels are pending at arbitration time, the lowest index wins (channel 0 has the highest priority and channel 3 the lowest).
- R5: Each channel holds one pending bit. Any number of sampled requests made while the bit is set leads to exactly one grant.
- R6: A channel's pending bit is cleared on the edge where its grant bit rises. A request sampled later, including during that channel's own transfer, sets the bit again.
- R7: A grant stays unchanged until `xfer_done_i` is seen. On the edge where `xfer_done_i` is sampled high, `grant_o` returns to 0.
- R8: After a transfer ends, no channel is granted until `cpu_done_i` has been sampled high. The earliest next grant is on the edge after that sample.
- R9: `grant_o` is zero or one-hot at all times, and `cpu_own_o` is 1 exactly when `grant_o` is 0.
- R10: A higher-priority request that becomes pending during a lower-priority transfer does not preempt it. It waits for arbitration after the next CPU access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | End-of-sampling-period strobe |
| ch_en_i | input | NCH | Per-channel enable |
| ch_req_i | input | NCH | Per-channel transfer request |
| xfer_done_i | input | 1 | Granted channel has finished its transfer |
| cpu_done_i | input | 1 | CPU has finished one bus access |
| grant_o | output | NCH | One-hot bus grant to a channel |
| cpu_own_o | output | 1 | CPU owns the bus |
| pend_o | output | NCH | Pending flag of each channel |

## Verification
On every cycle, the assertions check the following:
- the grant is zero or one-hot;
- a grant is held until `xfer_done_i` and is released on that edge;
- the bus stays with the CPU during the CPU turn;
- a newly raised grant goes to the highest-priority channel that was pending, and that channel's flag is cleared;
- pending flags of disabled channels stay clear.

Some behaviour depends on stimulus sequences, so only the bench scenarios can show it:
- the order of grants for simultaneous requests;
- repeated requests collapsing into a single transfer;
- a flag being set again after its grant;
- a higher-priority channel waiting behind a running transfer.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic [NCH-1:0] ch_req_i,
  input  logic           xfer_done_i,
  input  logic           cpu_done_i,
  output logic [NCH-1:0] grant_o,
  output logic           cpu_own_o,
  output logic [NCH-1:0] pend_o
);

  logic [NCH-1:0] pend_q, grant_q;
  logic           cpu_turn_q;

  wire            busy = |grant_q;
  wire            idle = !busy && !cpu_turn_q;
  wire [NCH-1:0]  pick = pend_q & (~pend_q + NCH'(1));
  wire [NCH-1:0]  win  = idle ? pick : '0;
  wire [NCH-1:0]  hits = sample_i ? (ch_req_i & ch_en_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      grant_q    <= '0;
      cpu_turn_q <= 1'b0;
    end else begin
      pend_q <= ((pend_q & ~win) | hits) & ch_en_i;
      if (busy) begin
        if (xfer_done_i) grant_q <= '0;
      end else if (idle) begin
        grant_q <= pick;
      end
      if (busy && xfer_done_i)  cpu_turn_q <= 1'b1;
      else if (cpu_done_i)      cpu_turn_q <= 1'b0;
    end
  end

  assign grant_o   = grant_q;
  assign cpu_own_o = !busy;
  assign pend_o    = pend_q;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R9
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done_i) |=> (grant_q == $past(grant_q))); // R7 R10
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done_i) |=> (grant_q == '0)); // R7
  AST_CPU_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_turn_q && !cpu_done_i) |=> (grant_q == '0)); // R8
  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy)) |-> ((($past(pend_q) & grant_q) == grant_q) && ((pend_q & grant_q & ~$past(hits)) == '0))); // R6
  AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy)) |-> (($past(pend_q) & (grant_q - NCH'(1))) == '0)); // R4
  AST_NO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(ch_en_i)) == '0)); // R3

endmodule

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0, sample_i = 0, xfer_done_i = 0, cpu_done_i = 0;
  logic [NCH-1:0] ch_en_i = '0, ch_req_i = '0, grant_o, pend_o;
  logic cpu_own_o;
  int checks = 0, fails = 0;
  int exp_q[$];
  bit auto_rsp = 0;
  logic [NCH-1:0] last_grant = '0;

  always #2 clk = ~clk;

  dma_req_arbiter #(.NCH(NCH)) i_dma_req_arbiter (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample(logic [NCH-1:0] r);
    ch_req_i = r; sample_i = 1; step(); sample_i = 0; ch_req_i = '0;
  endtask

  task automatic pulse_x();
    xfer_done_i = 1; step(); xfer_done_i = 0;
  endtask

  task automatic pulse_c();
    cpu_done_i = 1; step(); cpu_done_i = 0;
  endtask

  // monitor and auto responder
  always @(negedge clk) if (rst_n) begin
    check("R9 cpu_own", int'(cpu_own_o), int'(grant_o == '0));
    check("R9 onehot", int'($onehot0(grant_o)), 1);
    if (grant_o != '0 && last_grant == '0) begin
      if (exp_q.size() == 0) check("R4 unexpected grant", int'(grant_o), 0);
      else check("R4 grant order", int'(grant_o), 1 << exp_q.pop_front());
    end
    last_grant = grant_o;
    if (auto_rsp) begin
      xfer_done_i = (grant_o != '0);
      cpu_done_i  = cpu_own_o;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    check("R1 pend", int'(pend_o), 0);
    check("R1 grant", int'(grant_o), 0);
    check("R1 cpu_own", int'(cpu_own_o), 1);
    rst_n = 1; ch_en_i = '1; step();

    // R2: no sample strobe, no effect
    ch_req_i = 4'b1111; step(3); ch_req_i = '0;
    check("R2 no strobe", int'(pend_o), 0);

    // R2 R4 R6: simultaneous requests
    auto_rsp = 1;
    exp_q.push_back(0); exp_q.push_back(1);
    sample(4'b0011);
    check("R2 pend set", int'(pend_o), 3);
    step();
    check("R6 cleared at grant", int'(pend_o), 2);
    step(12);
    check("R4 queue drained", exp_q.size(), 0);
    auto_rsp = 0; xfer_done_i = 0; cpu_done_i = 0; step(2);

    // R10 R5 R3: lower channel holds bus
    exp_q.push_back(3);
    sample(4'b1000); step(2);
    check("R7 hold", int'(grant_o), 8);
    sample(4'b0001); step(3);
    check("R10 no preempt", int'(grant_o), 8);
    check("R10 pend waits", int'(pend_o), 1);
    sample(4'b0001); sample(4'b0001); sample(4'b0100);
    check("R2 pend two", int'(pend_o), 5);
    ch_en_i = 4'b1011; step();
    check("R3 disable clears", int'(pend_o), 1);
    sample(4'b0100);
    check("R3 disabled no set", int'(pend_o), 1);
    ch_en_i = '1;
    pulse_x();
    check("R7 release", int'(grant_o), 0);
    step(4);
    check("R8 cpu turn", int'(grant_o), 0);
    exp_q.push_back(0);
    pulse_c(); step();
    check("R8 grant after cpu", int'(grant_o), 1);
    check("R5 pend clear", int'(pend_o), 0);
    pulse_x(); pulse_c(); step(4);
    check("R5 single transfer", int'(grant_o), 0);
    check("R5 nothing left", int'(pend_o), 0);

    // R6: request during own transfer re-arms
    exp_q.push_back(0);
    sample(4'b0001); step();
    check("R6 granted", int'(grant_o), 1);
    check("R6 pend low", int'(pend_o), 0);
    sample(4'b0001);
    check("R6 re-armed", int'(pend_o), 1);
    exp_q.push_back(0);
    pulse_x(); pulse_c(); step();
    check("R6 second grant", int'(grant_o), 1);
    pulse_x(); pulse_c(); step(2);

    // R4: all four together
    auto_rsp = 1;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
    sample(4'b1111); step(25);
    check("R4 full order drained", exp_q.size(), 0);
    check("R4 final pend", int'(pend_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule